// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a lane-parallel integer unit for a 64-bit datapath. One operand word is treated as eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The lane size is chosen per operation. Carries and borrows never leave their lane.

The unit offers several families of operation:
- add and subtract that either wrap, clamp to the signed range, or clamp to the unsigned range;
- equality and signed greater-than compares that fill each lane with all ones or all zeros;
- four full-width bitwise operations;
- per-lane logical and arithmetic shifts by an unsigned count.

An operation and its operands enter on a valid/ready stream. The result leaves one clock later on a second valid/ready stream, from a single output register.

Back-pressure works as follows. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high while the output register is empty, or while its contents are being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output register holds its value and no new request is taken.

Top module: `simd_alu`

## Requirements
- R1: A request taken on a clock edge makes `out_valid` high with its result after that same edge. `in_ready` is high whenever the output register is empty or `out_ready` is high. With no new request, taking the output makes `out_valid` low after the next edge.
- R2: While `out_valid` is high and `out_ready` is low, `result` and `out_valid` hold and `in_ready` is low.
- R3: While `rst_n` is low, `out_valid` and `result` are zero. This holds even if reset arrives with a result pending.
- R4: Size code 0 selects 8-bit lanes, 1 selects 16-bit, 2 selects 32-bit and 3 selects 64-bit. Opcode 0 adds modulo the lane width at every size. Opcode 3 subtracts (a minus b) modulo the lane width for sizes 0 to 2. Neither lets a carry cross a lane boundary.
- R5: Opcode 1 (add) and opcode 4 (subtract), on sizes 0 and 1, treat lanes as two's complement. They clamp each lane to the most positive or most negative lane value on overflow.
- R6: Opcode 2 (add) and opcode 5 (subtract), on sizes 0 and 1, treat lanes as unsigned. Overflow of the add gives all ones; a subtract below zero gives zero.
- R7: Opcode 6 (equal) and opcode 7 (signed a greater than b), on sizes 0 to 2, write all ones into a lane where the test holds and all zeros where it fails.
- R8: Opcodes 8, 9, 10 and 11 give a AND b, (NOT a) AND b, a OR b and a XOR b over all 64 bits. The size code has no effect on them.
- R9: Opcode 12 (logical left) and opcode 13 (logical right) apply to sizes 1 to 3. Opcode 14 (arithmetic right) applies to sizes 1 and 2. Every lane of a is shifted by the unsigned `shamt` input.
- R10: A shift count equal to or above the lane width gives zero for opcodes 12 and 13. For opcode 14 it gives each lane's sign bit copied across the lane.
- R11: Opcode 15 gives a zero result, and so does any opcode paired with a size code outside those listed for it above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op | input | 4 | Opcode |
| size | input | 2 | Lane size code |
| a | input | DW (64) | First operand |
| b | input | DW (64) | Second operand |
| shamt | input | CW (8) | Shift count, unsigned |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result is taken this cycle |
| result | output | DW (64) | Registered result |

## Verification
The bench uses the default widths: a 64-bit operand and an 8-bit shift count. The 8-bit count reaches past every lane width, up to and beyond 64, so the zero and sign-fill cases of R10 can be driven at every shift size. The vector table sets lane patterns so that carries, borrows and overflows sit at lane edges, where any leak between lanes shows up in the neighbouring lane. Directed tests stall the output stream, change the offered request during the stall, and reset with a result pending.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDSS = 4'd1,
    OP_ADDUS = 4'd2,
    OP_SUB   = 4'd3,
    OP_SUBSS = 4'd4,
    OP_SUBUS = 4'd5,
    OP_CEQ   = 4'd6,
    OP_CGT   = 4'd7,
    OP_AND   = 4'd8,
    OP_ANDN  = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11,
    OP_SHL   = 4'd12,
    OP_SHR   = 4'd13,
    OP_SAR   = 4'd14,
    OP_NONE  = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } size_e;

  localparam int NUM_SIZES = 4;
  localparam int BASE_LANE = 8;
endpackage

// File: rtl/simd_lane_ops.sv
// All lane-wise arithmetic, compare and shift results for one lane width.
module simd_lane_ops #(
  parameter int DW = 64,
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [CW-1:0] shamt,
  output logic [DW-1:0] add_w,
  output logic [DW-1:0] sub_w,
  output logic [DW-1:0] add_ss,
  output logic [DW-1:0] add_us,
  output logic [DW-1:0] sub_ss,
  output logic [DW-1:0] sub_us,
  output logic [DW-1:0] ceq,
  output logic [DW-1:0] cgt,
  output logic [DW-1:0] shl,
  output logic [DW-1:0] shr,
  output logic [DW-1:0] sar
);
  localparam int NL = DW / LW;
  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  logic over;
  assign over = (32'(shamt) >= 32'(LW));

  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [LW-1:0] x, y;
    logic [LW:0]   s, d;
    logic          sx, sy, ovf_a, ovf_s;

    assign x  = a[i*LW +: LW];
    assign y  = b[i*LW +: LW];
    assign sx = x[LW-1];
    assign sy = y[LW-1];
    assign s  = {1'b0, x} + {1'b0, y};
    assign d  = {1'b0, x} - {1'b0, y};

    assign ovf_a = (sx == sy) && (s[LW-1] != sx);
    assign ovf_s = (sx != sy) && (d[LW-1] != sx);

    assign add_w [i*LW +: LW] = s[LW-1:0];
    assign sub_w [i*LW +: LW] = d[LW-1:0];
    assign add_ss[i*LW +: LW] = ovf_a ? (sx ? SMIN : SMAX) : s[LW-1:0];
    assign sub_ss[i*LW +: LW] = ovf_s ? (sx ? SMIN : SMAX) : d[LW-1:0];
    assign add_us[i*LW +: LW] = s[LW] ? {LW{1'b1}} : s[LW-1:0];
    assign sub_us[i*LW +: LW] = d[LW] ? {LW{1'b0}} : d[LW-1:0];
    assign ceq   [i*LW +: LW] = {LW{x == y}};
    assign cgt   [i*LW +: LW] = {LW{$signed(x) > $signed(y)}};
    assign shl   [i*LW +: LW] = over ? {LW{1'b0}} : (x << shamt);
    assign shr   [i*LW +: LW] = over ? {LW{1'b0}} : (x >> shamt);
    assign sar   [i*LW +: LW] = over ? {LW{sx}} : LW'($signed(x) >>> shamt);
  end
endmodule

// File: rtl/simd_bitwise.sv
// Full-width bitwise operations; lane size is irrelevant here.
module simd_bitwise #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (sel)
      2'd0:    y = a & b;
      2'd1:    y = ~a & b;
      2'd2:    y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op,
  input  logic [1:0]    size,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [CW-1:0] shamt,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] result
);
  logic [DW-1:0] r_add  [NUM_SIZES];
  logic [DW-1:0] r_sub  [NUM_SIZES];
  logic [DW-1:0] r_adss [NUM_SIZES];
  logic [DW-1:0] r_adus [NUM_SIZES];
  logic [DW-1:0] r_sbss [NUM_SIZES];
  logic [DW-1:0] r_sbus [NUM_SIZES];
  logic [DW-1:0] r_ceq  [NUM_SIZES];
  logic [DW-1:0] r_cgt  [NUM_SIZES];
  logic [DW-1:0] r_shl  [NUM_SIZES];
  logic [DW-1:0] r_shr  [NUM_SIZES];
  logic [DW-1:0] r_sar  [NUM_SIZES];
  logic [DW-1:0] r_bit;
  logic [DW-1:0] nxt;
  op_e           opc;
  size_e         sz;
  logic          fire;

  assign opc = op_e'(op);
  assign sz  = size_e'(size);

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    simd_lane_ops #(.DW(DW), .LW(BASE_LANE << k), .CW(CW)) u_ops (
      .a     (a),
      .b     (b),
      .shamt (shamt),
      .add_w (r_add[k]),
      .sub_w (r_sub[k]),
      .add_ss(r_adss[k]),
      .add_us(r_adus[k]),
      .sub_ss(r_sbss[k]),
      .sub_us(r_sbus[k]),
      .ceq   (r_ceq[k]),
      .cgt   (r_cgt[k]),
      .shl   (r_shl[k]),
      .shr   (r_shr[k]),
      .sar   (r_sar[k])
    );
  end

  simd_bitwise #(.DW(DW)) u_bit (
    .a  (a),
    .b  (b),
    .sel(op[1:0]),
    .y  (r_bit)
  );

  always_comb begin
    nxt = '0;
    unique case (opc)
      OP_ADD:   nxt = r_add[size];
      OP_SUB:   if (sz != SZ_64) nxt = r_sub[size];
      OP_ADDSS: if (sz == SZ_8 || sz == SZ_16) nxt = r_adss[size];
      OP_ADDUS: if (sz == SZ_8 || sz == SZ_16) nxt = r_adus[size];
      OP_SUBSS: if (sz == SZ_8 || sz == SZ_16) nxt = r_sbss[size];
      OP_SUBUS: if (sz == SZ_8 || sz == SZ_16) nxt = r_sbus[size];
      OP_CEQ:   if (sz != SZ_64) nxt = r_ceq[size];
      OP_CGT:   if (sz != SZ_64) nxt = r_cgt[size];
      OP_AND, OP_ANDN, OP_OR, OP_XOR: nxt = r_bit;
      OP_SHL:   if (sz != SZ_8) nxt = r_shl[size];
      OP_SHR:   if (sz != SZ_8) nxt = r_shr[size];
      OP_SAR:   if (sz == SZ_16 || sz == SZ_32) nxt = r_sar[size];
      default:  nxt = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      result    <= nxt;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    op,
  input logic [1:0]    size,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic [CW-1:0] shamt,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] result
);
  logic take;
  assign take = in_valid && in_ready;

  function automatic logic lanes_solid(input logic [1:0] sz, input logic [DW-1:0] r);
    int lw;
    logic ok;
    lw = 8 << sz;
    ok = 1'b1;
    for (int i = 0; i < DW; i++) begin
      if (r[i] != r[(i / lw) * lw]) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic unsupported(input logic [3:0] o, input logic [1:0] sz);
    case (o)
      4'd0, 4'd8, 4'd9, 4'd10, 4'd11: return 1'b0;
      4'd1, 4'd2, 4'd4, 4'd5:         return sz > 2'd1;
      4'd3, 4'd6, 4'd7:               return sz == 2'd3;
      4'd12, 4'd13:                   return sz == 2'd0;
      4'd14:                          return !(sz == 2'd1 || sz == 2'd2);
      default:                        return 1'b1;
    endcase
  endfunction

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result));

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R7
  cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && (op == 4'd6 || op == 4'd7) |=> lanes_solid($past(size), result));

  // R11
  unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && unsupported(op, size) |=> result == '0);

  // R8
  and_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == 4'd8 |=> result == $past(a & b));

  // R4
  wide_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == 4'd0 && size == 2'd3 |=> result == $past(a + b));
endmodule

bind simd_alu simd_alu_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .op       (op),
  .size     (size),
  .a        (a),
  .b        (b),
  .shamt    (shamt),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .result   (result)
);

// File: tb/test_simd_alu.sv
`timescale 1ns/1ps
module test_simd_alu;
  localparam int DW = 64;
  localparam int CW = 8;
  localparam int NV = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [3:0]    op = '0;
  logic [1:0]    size = '0;
  logic [DW-1:0] a = '0;
  logic [DW-1:0] b = '0;
  logic [CW-1:0] shamt = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_alu #(.DW(DW), .CW(CW)) i_simd_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .size(size), .a(a), .b(b), .shamt(shamt),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  // Columns: opcode, size, a, b, shift count, expected, requirement
  localparam logic [3:0] V_OP [NV] = '{
    4'd0, 4'd0, 4'd0, 4'd3,          // R4
    4'd1, 4'd4,                      // R5
    4'd2, 4'd5,                      // R6
    4'd6, 4'd7, 4'd7,                // R7
    4'd8, 4'd9, 4'd10, 4'd11,        // R8
    4'd12, 4'd13, 4'd14, 4'd12,      // R9
    4'd13, 4'd14, 4'd12,             // R10
    4'd1, 4'd14, 4'd15, 4'd3, 4'd6   // R11
  };
  localparam logic [1:0] V_SZ [NV] = '{
    2'd0, 2'd3, 2'd2, 2'd1,
    2'd0, 2'd1,
    2'd0, 2'd1,
    2'd0, 2'd1, 2'd2,
    2'd2, 2'd0, 2'd3, 2'd1,
    2'd1, 2'd2, 2'd1, 2'd3,
    2'd1, 2'd2, 2'd3,
    2'd2, 2'd0, 2'd0, 2'd3, 2'd3
  };
  localparam logic [63:0] V_A [NV] = '{
    64'h01FF_7F80_1234_00FF, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h0000_0005_8000_0001,
    64'h7F80_10F0_7F80_01FF, 64'h8000_7FFF_0005_FFFF,
    64'hFF80_0100_F07F_10FE, 64'h0005_FFFF_0000_8000,
    64'h1122_3344_5566_7788, 64'h0001_8000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF,
    64'hF0F0_F0F0_FFFF_0000, 64'hF0F0_F0F0_FFFF_0000, 64'hF0F0_F0F0_FFFF_0000, 64'hF0F0_F0F0_FFFF_0000,
    64'h1234_8001_FFFF_0F0F, 64'h8000_00FF_1234_5678, 64'h8000_7FF0_F00F_0010, 64'h0000_0000_0000_0003,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0001_0000_0001, 64'hF0F0_F0F0_F0F0_F0F0, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0000_0009,
    64'h5555_5555_5555_5555
  };
  localparam logic [63:0] V_B [NV] = '{
    64'h0101_0180_0100_0001, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h0001_0003_0001_0002,
    64'h01FF_20F0_8080_7F01, 64'h0001_FFFF_0007_8000,
    64'h0180_0100_2080_2001, 64'h0007_0001_0000_7FFF,
    64'h1100_3300_5500_7700, 64'h0000_7FFF_7FFF_FFFE, 64'hFFFF_FFFF_0000_0000,
    64'hFF00_FF00_0F0F_FFFF, 64'hFF00_FF00_0F0F_FFFF, 64'hFF00_FF00_0F0F_FFFF, 64'hFF00_FF00_0F0F_FFFF,
    64'h0, 64'h0, 64'h0, 64'h0,
    64'h0, 64'h0, 64'h0,
    64'h0000_0001_0000_0001, 64'h0, 64'h1111_1111_1111_1111, 64'h0000_0000_0000_0001,
    64'h5555_5555_5555_5555
  };
  localparam logic [7:0] V_CNT [NV] = '{
    8'd0, 8'd0, 8'd0, 8'd0,
    8'd0, 8'd0,
    8'd0, 8'd0,
    8'd0, 8'd0, 8'd0,
    8'd0, 8'd0, 8'd0, 8'd0,
    8'd4, 8'd8, 8'd4, 8'd63,
    8'd16, 8'd40, 8'd64,
    8'd0, 8'd2, 8'd0, 8'd0, 8'd0
  };
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0200_8000_1334_0000, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0000, 64'hFFFF_0002_7FFF_FFFF,
    64'h7F80_30E0_FF80_7F00, 64'h8000_7FFF_FFFE_7FFF,
    64'hFFFF_0200_FFFF_30FF, 64'h0000_FFFE_0000_0001,
    64'hFF00_FF00_FF00_FF00, 64'hFFFF_0000_0000_FFFF, 64'hFFFF_FFFF_0000_0000,
    64'hF000_F000_0F0F_0000, 64'h0F00_0F00_0000_FFFF, 64'hFFF0_FFF0_FFFF_FFFF, 64'h0FF0_0FF0_F0F0_FFFF,
    64'h2340_0010_FFF0_F0F0, 64'h0080_0000_0012_3456, 64'hF800_07FF_FF00_0001, 64'h8000_0000_0000_0000,
    64'h0, 64'hFFFF_FFFF_0000_0000, 64'h0,
    64'h0, 64'h0, 64'h0, 64'h0, 64'h0
  };
  localparam int V_REQ [NV] = '{
    4, 4, 4, 4, 5, 5, 6, 6, 7, 7, 7, 8, 8, 8, 8,
    9, 9, 9, 9, 10, 10, 10, 11, 11, 11, 11, 11
  };

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    in_valid = 1'b1;
    op = 4'd0;
    a = 64'h1;
    b = 64'h1;
    repeat (3) @(negedge clk);
    // R3: held in reset with a request offered
    check({63'd0, out_valid}, 64'd0, "R3");
    check(result, 64'd0, "R3");
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty output lets requests in
    check({63'd0, in_ready}, 64'd1, "R1");

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      op = V_OP[k]; size = V_SZ[k]; a = V_A[k]; b = V_B[k]; shamt = V_CNT[k];
      in_valid = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({63'd0, out_valid}, 64'd1, "R1");
      check(result, V_EXP[k], $sformatf("R%0d", V_REQ[k]));
    end

    // R2: stall the output, then release it with a new request waiting
    @(negedge clk);
    op = 4'd10; size = 2'd0; a = 64'h00FF; b = 64'hFF00; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check({63'd0, out_valid}, 64'd1, "R1");
    check(result, 64'hFFFF, "R1");
    check({63'd0, in_ready}, 64'd0, "R2");
    a = 64'h0F00; b = 64'h00F0;
    repeat (2) @(negedge clk);
    check(result, 64'hFFFF, "R2");
    check({63'd0, out_valid}, 64'd1, "R2");
    out_ready = 1'b1;
    #0.1;
    check({63'd0, in_ready}, 64'd1, "R1");
    @(negedge clk);
    in_valid = 1'b0;
    check(result, 64'h0FF0, "R2");
    @(negedge clk);
    check({63'd0, out_valid}, 64'd0, "R1");

    // R3: reset arriving with a result pending
    op = 4'd0; size = 2'd3; a = 64'd5; b = 64'd6; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(result, 64'd11, "R4");
    rst_n = 1'b0;
    #0.5;
    check({63'd0, out_valid}, 64'd0, "R3");
    check(result, 64'd0, "R3");
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule